// File: doc/BRIEF.md
# Script Transfer-Control Branch Unit

This unit executes the flow-control instructions of a small script processor that sequences a SCSI bus: jump, call, return, interrupt and interrupt-on-the-fly. The instruction fetcher presents both 32-bit words of an instruction, with the address of its first word, and pulses `issue`. The unit evaluates the branch condition, then returns the address the fetcher should read next. It also keeps a one-entry link register for subroutines and raises either a halting interrupt or a non-halting notification to the host, each carrying a 32-bit vector.

A branch condition can test the bus phase, a masked compare against the most recently received data byte, and a carry flag. All enabled tests must pass. A sense bit then either keeps or inverts the combined result. A phase test checks the phase latched now, or it waits for the next REQ and checks the phase seen then. While the unit waits, it reports busy and ignores new issues. After a halting interrupt it ignores issues until the host pulses `resume`.

Instruction word 0 layout: bits 31:30 = `10` select this class. Bits 29:27 hold the opcode. Bit 23 selects a relative target, bit 21 waits for REQ, and bit 20 marks an interrupt as on-the-fly. Bits 26:24 hold the expected phase. Bit 19 enables the carry test, bit 18 is the sense (1 = act when the condition is true), bit 17 enables the data test and bit 16 enables the phase test. Bits 15:8 are the compare mask and bits 7:0 the compare byte. Word 1 is the absolute target, or in its low 24 bits a signed offset, or the interrupt vector.

Top module: `xbu_top`

## Requirements
- R1: After reset, `ptr_valid`, `halted`, `irq_fly`, `busy` are 0 and `link_addr` is 0.
- R2: An issue whose word 0 bits 31:30 are not `10` produces no `ptr_valid` and changes nothing.
- R3: A jump (opcode 000) with no wait is resolved one cycle after issue. When taken, `ptr_next` is word 1. When not taken, `ptr_next` is the instruction address + 8.
- R4: With bit 23 set, a taken branch goes to the instruction address + 8 + the sign-extended word 1 bits 23:0.
- R5: A taken call (opcode 001) branches and loads `link_addr` with the instruction address + 8. A call that is not taken leaves `link_addr` unchanged.
- R6: A taken return (opcode 010) sets `ptr_next` to `link_addr`. Only one level is held, so a second call overwrites it.
- R7: Without bit 21, the phase test compares bits 26:24 with `phase_now`.
- R8: With bit 21 set, the unit holds `busy` high with no `ptr_valid` and ignores issues until `req_seen`. It then resolves in the next cycle using `phase_req`.
- R9: The data test passes when every bit of `rx_byte` equals bits 7:0 wherever the mask bit is 0. Bits whose mask bit is 1 are ignored.
- R10: The carry test passes when `carry` is 1.
- R11: All enabled tests must pass to give the condition, and a sense bit of 0 inverts it. With no tests enabled, the condition is true.
- R12: A taken interrupt (opcode 011, bit 20 clear) sets `halted`, puts word 1 on `vector` and gives `ptr_next` = address + 8. Issues are ignored until `resume`, which clears `halted` one cycle later.
- R13: A taken on-the-fly interrupt raises `irq_fly` for one cycle with `vector` = word 1, does not halt, and continues at address + 8.
- R14: Opcodes 100–111 and interrupts that are not taken only advance `ptr_next` to address + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue | input | 1 | Instruction words and address are valid |
| instr_w0 | input | 32 | First instruction word |
| instr_w1 | input | 32 | Second instruction word |
| instr_addr | input | ADDR_W | Address of the first word |
| phase_now | input | 3 | Currently latched bus phase |
| phase_req | input | 3 | Phase presented at the next REQ |
| req_seen | input | 1 | Next REQ has asserted |
| rx_byte | input | 8 | Most recent received data byte |
| carry | input | 1 | Carry flag |
| resume | input | 1 | Host release after a halting interrupt |
| ptr_valid | output | 1 | One-cycle pulse, `ptr_next` valid |
| ptr_next | output | ADDR_W | Next fetch address |
| link_addr | output | ADDR_W | One-entry return register |
| busy | output | 1 | Waiting for REQ |
| halted | output | 1 | Halted by interrupt |
| irq_fly | output | 1 | One-cycle non-halting interrupt |
| vector | output | 32 | Interrupt vector |

## Verification
The hardest state to reach is the wait for REQ, because in that state the conditions must come from the latched instruction while the live inputs keep changing. The bench issues a phase-waiting jump. It then drives a different instruction and another `issue` during the wait, and raises `req_seen` only after several cycles with a new `phase_req`. The test passes only if the first instruction's target and phase are used. The halt case is reached the same way: an issue is presented during the halt and again in the cycle of `resume`.

// File: rtl/xbu_pkg.sv
package xbu_pkg;
    localparam int INSTR_W = 32;
    localparam int PHASE_W = 3;
    localparam int BYTE_W  = 8;

    localparam logic [1:0] CLASS_XFER = 2'b10;
    localparam logic [2:0] OP_JUMP = 3'b000;
    localparam logic [2:0] OP_CALL = 3'b001;
    localparam logic [2:0] OP_RET  = 3'b010;
    localparam logic [2:0] OP_INT  = 3'b011;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_WAIT = 2'd1,
        M_HALT = 2'd2
    } xbu_mode_e;

    typedef struct packed {
        logic               is_xfer;
        logic [2:0]         op;
        logic               rel;
        logic               wait_req;
        logic               fly;
        logic [PHASE_W-1:0] phase;
        logic               carry_en;
        logic               sense;
        logic               data_en;
        logic               phase_en;
        logic [BYTE_W-1:0]  mask;
        logic [BYTE_W-1:0]  data;
    } xbu_dec_t;
endpackage

// File: rtl/xbu_decode.sv
module xbu_decode
    import xbu_pkg::*;
(
    input  logic [INSTR_W-1:0] w0,
    output xbu_dec_t           dec
);
    logic unused_rsv;

    always_comb begin
        dec.is_xfer  = (w0[31:30] == CLASS_XFER);
        dec.op       = w0[29:27];
        dec.phase    = w0[26:24];
        dec.rel      = w0[23];
        dec.wait_req = w0[21];
        dec.fly      = w0[20];
        dec.carry_en = w0[19];
        dec.sense    = w0[18];
        dec.data_en  = w0[17];
        dec.phase_en = w0[16];
        dec.mask     = w0[15:8];
        dec.data     = w0[7:0];
    end

    assign unused_rsv = w0[22];
endmodule

// File: rtl/xbu_cond_eval.sv
module xbu_cond_eval
    import xbu_pkg::*;
(
    input  xbu_dec_t           dec,
    input  logic [PHASE_W-1:0] phase_sel,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               carry,
    output logic               taken
);
    logic [BYTE_W-1:0] bit_ok;
    logic              data_ok;
    logic              phase_ok;
    logic              cond;

    // per-bit compare; a set mask bit removes the bit from the test
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        assign bit_ok[b] = dec.mask[b] | ~(rx_byte[b] ^ dec.data[b]);
    end

    always_comb begin
        data_ok  = &bit_ok;
        phase_ok = (phase_sel == dec.phase);
        cond     = (~dec.carry_en | carry)
                 & (~dec.data_en  | data_ok)
                 & (~dec.phase_en | phase_ok);
        taken    = dec.sense ? cond : ~cond;
    end
endmodule

// File: rtl/xbu_target.sv
module xbu_target
    import xbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 24,
    parameter int STEP   = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [INSTR_W-1:0] w1,
    input  logic               rel,
    output logic [ADDR_W-1:0]  seq_addr,
    output logic [ADDR_W-1:0]  br_addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] abs_addr;

    if (OFFS_W < ADDR_W) begin : g_sext
        assign off_ext = {{(ADDR_W-OFFS_W){w1[OFFS_W-1]}}, w1[OFFS_W-1:0]};
    end else begin : g_trunc
        assign off_ext = w1[ADDR_W-1:0];
    end

    if (ADDR_W < INSTR_W) begin : g_abs_narrow
        assign abs_addr = w1[ADDR_W-1:0];
    end else begin : g_abs_full
        assign abs_addr = w1;
    end

    always_comb begin
        seq_addr = base + STEP_V;
        br_addr  = rel ? (seq_addr + off_ext) : abs_addr;
    end
endmodule

// File: rtl/xbu_top.sv
module xbu_top
    import xbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 24,
    parameter int STEP   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [31:0]         instr_w0,
    input  logic [31:0]         instr_w1,
    input  logic [ADDR_W-1:0]   instr_addr,
    input  logic [2:0]          phase_now,
    input  logic [2:0]          phase_req,
    input  logic                req_seen,
    input  logic [7:0]          rx_byte,
    input  logic                carry,
    input  logic                resume,
    output logic                ptr_valid,
    output logic [ADDR_W-1:0]   ptr_next,
    output logic [ADDR_W-1:0]   link_addr,
    output logic                busy,
    output logic                halted,
    output logic                irq_fly,
    output logic [31:0]         vector
);
    typedef struct packed {
        xbu_mode_e          mode;
        logic [INSTR_W-1:0] w0;
        logic [INSTR_W-1:0] w1;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  link;
        logic [ADDR_W-1:0]  nxt;
        logic [INSTR_W-1:0] vec;
        logic               done;
        logic               fly;
    } xbu_state_t;

    xbu_state_t st_d, st_q;

    logic               use_lat;
    logic [INSTR_W-1:0] w0_sel, w1_sel;
    logic [ADDR_W-1:0]  addr_sel;
    logic [PHASE_W-1:0] phase_sel;
    xbu_dec_t           dec;
    logic               taken;
    logic [ADDR_W-1:0]  seq_addr, br_addr;
    logic               start, eval;

    always_comb begin
        use_lat   = (st_q.mode == M_WAIT);
        w0_sel    = use_lat ? st_q.w0   : instr_w0;
        w1_sel    = use_lat ? st_q.w1   : instr_w1;
        addr_sel  = use_lat ? st_q.addr : instr_addr;
        phase_sel = use_lat ? phase_req : phase_now;
    end

    xbu_decode u_dec (
        .w0  (w0_sel),
        .dec (dec)
    );

    xbu_cond_eval u_cond (
        .dec       (dec),
        .phase_sel (phase_sel),
        .rx_byte   (rx_byte),
        .carry     (carry),
        .taken     (taken)
    );

    xbu_target #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .STEP(STEP)) u_tgt (
        .base     (addr_sel),
        .w1       (w1_sel),
        .rel      (dec.rel),
        .seq_addr (seq_addr),
        .br_addr  (br_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.fly  = 1'b0;
        start = (st_q.mode == M_IDLE) && issue && dec.is_xfer;
        eval  = (start && !dec.wait_req) || (use_lat && req_seen);

        if (start && dec.wait_req) begin
            st_d.mode = M_WAIT;
            st_d.w0   = instr_w0;
            st_d.w1   = instr_w1;
            st_d.addr = instr_addr;
        end

        if (st_q.mode == M_HALT && resume) begin
            st_d.mode = M_IDLE;
        end

        if (eval) begin
            st_d.done = 1'b1;
            st_d.mode = M_IDLE;
            st_d.nxt  = seq_addr;
            if (taken) begin
                case (dec.op)
                    OP_JUMP: st_d.nxt = br_addr;
                    OP_CALL: begin
                        st_d.nxt  = br_addr;
                        st_d.link = seq_addr;
                    end
                    OP_RET:  st_d.nxt = st_q.link;
                    OP_INT: begin
                        st_d.vec = w1_sel;
                        if (dec.fly) st_d.fly  = 1'b1;
                        else         st_d.mode = M_HALT;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_valid = st_q.done;
    assign ptr_next  = st_q.nxt;
    assign link_addr = st_q.link;
    assign busy      = (st_q.mode == M_WAIT);
    assign halted    = (st_q.mode == M_HALT);
    assign irq_fly   = st_q.fly;
    assign vector    = st_q.vec;

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> halted);

    assert_resume_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && resume) |=> (!halted && !ptr_valid));

    assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_seen) |=> (busy && !ptr_valid));

    assert_call_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && taken && dec.op == OP_CALL) |=> (link_addr == $past(addr_sel) + ADDR_W'(STEP)));

    assert_return_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && taken && dec.op == OP_RET) |=> (ptr_next == $past(link_addr)));

    assert_fly_no_halt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fly |-> (!halted && ptr_valid));

    assert_foreign_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !halted && issue && instr_w0[31:30] != 2'b10) |=> !ptr_valid);
endmodule

// File: tb/xbu_top_tb.sv
module xbu_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue = 0;
    logic [31:0] instr_w0 = 0, instr_w1 = 0, instr_addr = 0;
    logic [2:0]  phase_now = 0, phase_req = 0;
    logic        req_seen = 0;
    logic [7:0]  rx_byte = 0;
    logic        carry = 0, resume = 0;
    logic        ptr_valid, busy, halted, irq_fly;
    logic [31:0] ptr_next, link_addr, vector;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbu_top u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr_w0(instr_w0),
        .instr_w1(instr_w1), .instr_addr(instr_addr), .phase_now(phase_now),
        .phase_req(phase_req), .req_seen(req_seen), .rx_byte(rx_byte),
        .carry(carry), .resume(resume), .ptr_valid(ptr_valid),
        .ptr_next(ptr_next), .link_addr(link_addr), .busy(busy),
        .halted(halted), .irq_fly(irq_fly), .vector(vector)
    );

    function automatic logic [31:0] mk(input logic [2:0] op, input logic rel,
        input logic wt, input logic fly, input logic [2:0] ph, input logic cen,
        input logic sense, input logic den, input logic pen,
        input logic [7:0] mask, input logic [7:0] data);
        return {2'b10, op, ph, rel, 1'b0, wt, fly, cen, sense, den, pen, mask, data};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_issue(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] a);
        @(negedge clk);
        instr_w0 = w0; instr_w1 = w1; instr_addr = a; issue = 1;
        @(negedge clk);
        issue = 0;
    endtask

    task automatic t_reset();
        chk("R1 valid", ptr_valid, 0); chk("R1 halted", halted, 0);
        chk("R1 fly", irq_fly, 0);     chk("R1 busy", busy, 0);
        chk("R1 link", link_addr, 0);
    endtask

    task automatic t_class();
        do_issue(32'h4000_0000, 32'h1000, 32'h100);
        chk("R2 foreign class", ptr_valid, 0);
        chk("R2 link", link_addr, 0);
    endtask

    task automatic t_jump();
        do_issue(mk(3'b000,0,0,0,0,0,1,0,0,0,0), 32'h2000, 32'h100);
        chk("R3 taken valid", ptr_valid, 1); chk("R3 taken", ptr_next, 32'h2000);
        do_issue(mk(3'b000,0,0,0,0,0,0,0,0,0,0), 32'h2000, 32'h100);
        chk("R3 not taken", ptr_next, 32'h108);
        @(negedge clk);
        chk("R3 single pulse", ptr_valid, 0);
    endtask

    task automatic t_rel();
        do_issue(mk(3'b000,1,0,0,0,0,1,0,0,0,0), 32'h00FF_FFF0, 32'h100);
        chk("R4 negative", ptr_next, 32'hF8);
        do_issue(mk(3'b000,1,0,0,0,0,1,0,0,0,0), 32'h0000_0040, 32'h100);
        chk("R4 positive", ptr_next, 32'h148);
    endtask

    task automatic t_call_ret();
        do_issue(mk(3'b001,0,0,0,0,0,1,0,0,0,0), 32'h4000, 32'h300);
        chk("R5 call target", ptr_next, 32'h4000);
        chk("R5 link", link_addr, 32'h308);
        do_issue(mk(3'b001,0,0,0,0,0,0,0,0,0,0), 32'h6000, 32'h400);
        chk("R5 untaken call", ptr_next, 32'h408);
        chk("R5 link kept", link_addr, 32'h308);
        do_issue(mk(3'b010,0,0,0,0,0,1,0,0,0,0), 32'h0, 32'h4000);
        chk("R6 return", ptr_next, 32'h308);
        do_issue(mk(3'b001,0,0,0,0,0,1,0,0,0,0), 32'h5000, 32'h500);
        do_issue(mk(3'b001,0,0,0,0,0,1,0,0,0,0), 32'h7000, 32'h5000);
        do_issue(mk(3'b010,0,0,0,0,0,1,0,0,0,0), 32'h0, 32'h7000);
        chk("R6 one level", ptr_next, 32'h5008);
    endtask

    task automatic t_phase_if();
        phase_now = 3'd2; phase_req = 3'd5;
        do_issue(mk(3'b000,0,0,0,3'd2,0,1,0,1,0,0), 32'hA000, 32'h100);
        chk("R7 match", ptr_next, 32'hA000);
        do_issue(mk(3'b000,0,0,0,3'd5,0,1,0,1,0,0), 32'hA000, 32'h100);
        chk("R7 mismatch", ptr_next, 32'h108);
    endtask

    task automatic t_when();
        phase_now = 3'd1; phase_req = 3'd0;
        do_issue(mk(3'b000,0,1,0,3'd5,0,1,0,1,0,0), 32'hB000, 32'h200);
        chk("R8 busy", busy, 1); chk("R8 no valid", ptr_valid, 0);
        do_issue(mk(3'b000,0,0,0,0,0,1,0,0,0,0), 32'h9000, 32'h900);
        chk("R8 issue ignored", ptr_valid, 0);
        @(negedge clk); @(negedge clk);
        chk("R8 still busy", busy, 1);
        phase_req = 3'd5; req_seen = 1;
        @(negedge clk);
        req_seen = 0;
        chk("R8 resolved", ptr_valid, 1); chk("R8 target", ptr_next, 32'hB000);
        chk("R8 idle", busy, 0);
        do_issue(mk(3'b000,0,1,0,3'd5,0,1,0,1,0,0), 32'hB000, 32'h200);
        phase_req = 3'd3; req_seen = 1;
        @(negedge clk);
        req_seen = 0;
        chk("R8 req mismatch", ptr_next, 32'h208);
    endtask

    task automatic t_data();
        rx_byte = 8'hA5;
        do_issue(mk(3'b000,0,0,0,0,0,1,1,0,8'h0F,8'hA0), 32'hC000, 32'h100);
        chk("R9 masked pass", ptr_next, 32'hC000);
        do_issue(mk(3'b000,0,0,0,0,0,1,1,0,8'h03,8'hA0), 32'hC000, 32'h100);
        chk("R9 unmasked fail", ptr_next, 32'h108);
    endtask

    task automatic t_carry();
        carry = 1;
        do_issue(mk(3'b000,0,0,0,0,1,1,0,0,0,0), 32'hD000, 32'h100);
        chk("R10 carry set", ptr_next, 32'hD000);
        carry = 0;
        do_issue(mk(3'b000,0,0,0,0,1,1,0,0,0,0), 32'hD000, 32'h100);
        chk("R10 carry clear", ptr_next, 32'h108);
    endtask

    task automatic t_combo();
        phase_now = 3'd2; rx_byte = 8'h11;
        do_issue(mk(3'b000,0,0,0,3'd2,0,1,1,1,8'h00,8'h22), 32'hE000, 32'h100);
        chk("R11 both needed", ptr_next, 32'h108);
        do_issue(mk(3'b000,0,0,0,3'd2,0,1,1,1,8'h00,8'h11), 32'hE000, 32'h100);
        chk("R11 both pass", ptr_next, 32'hE000);
        do_issue(mk(3'b000,0,0,0,3'd6,0,0,0,1,0,0), 32'hE000, 32'h100);
        chk("R11 negated", ptr_next, 32'hE000);
    endtask

    task automatic t_int();
        do_issue(mk(3'b011,0,0,0,0,0,1,0,0,0,0), 32'hDEAD_0001, 32'h700);
        chk("R12 halted", halted, 1); chk("R12 vector", vector, 32'hDEAD_0001);
        chk("R12 ptr", ptr_next, 32'h708);
        do_issue(mk(3'b000,0,0,0,0,0,1,0,0,0,0), 32'h9000, 32'h900);
        chk("R12 issue ignored", ptr_valid, 0); chk("R12 still halted", halted, 1);
        @(negedge clk);
        resume = 1; issue = 1;
        @(negedge clk);
        resume = 0; issue = 0;
        chk("R12 released", halted, 0); chk("R12 resume cycle ignored", ptr_valid, 0);
        do_issue(mk(3'b011,0,0,0,0,0,0,0,0,0,0), 32'h1111, 32'h740);
        chk("R14 untaken int", halted, 0); chk("R14 untaken ptr", ptr_next, 32'h748);
    endtask

    task automatic t_fly();
        do_issue(mk(3'b011,0,0,1,0,0,1,0,0,0,0), 32'h0000_0055, 32'h800);
        chk("R13 fly", irq_fly, 1); chk("R13 no halt", halted, 0);
        chk("R13 vector", vector, 32'h55); chk("R13 ptr", ptr_next, 32'h808);
        @(negedge clk);
        chk("R13 one cycle", irq_fly, 0);
    endtask

    task automatic t_reserved();
        do_issue(mk(3'b101,0,0,0,0,0,1,0,0,0,0), 32'h1234, 32'h900);
        chk("R14 reserved ptr", ptr_next, 32'h908);
        chk("R14 link kept", link_addr, 32'h5008);
        chk("R14 no halt", halted, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset(); t_class(); t_jump(); t_rel(); t_call_ret();
                t_phase_if(); t_when(); t_data(); t_carry(); t_combo();
                t_int(); t_fly(); t_reserved();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule